// File: doc/BRIEF.md
# SPI Slave Transfer Engine with Mode-Fault Shutdown

This block is an SPI slave that moves 8-bit frames in clock mode 0 (SCK idles low, MOSI captured on the rising edge, MISO changed after the falling edge, most significant bit first). SCK, MOSI and the active-low select are brought into the system clock domain through two-flop synchronisers. Edges of SCK are found in that domain, so the system clock must run at least four times faster than SCK. MISO comes with a separate output-enable, so a pad can float the line whenever the block is not driving it.

Software reaches the block through a small register port with four addresses. Address 0 is the control word. Address 1 is the status word. Address 2 holds the transmit byte on writes and returns the last received byte on reads. While the block is a slave with fault detection on, a release of select in the middle of a frame is a mode fault. The fault sets a sticky flag, clears the enable by itself, floats MISO and aborts the frame. Software cannot enable the block again until it clears the flag. To clear it, software must read the status word while the flag is set and then write 0 to the flag. An optional error interrupt follows the flag.

Top module: `spi_slave_guard`

## Requirements
- R1: After reset every control and status bit is 0, `reg_rdata` reads 0 at the control and status addresses, and `spi_miso_oe`, `irq_err` and `rx_valid` are 0.
- R2: While enabled as a slave (control bit 0 = enable set, control bit 1 = master-select clear) with select low, 8 MOSI bits are shifted in MSB first on rising SCK. After the 8th bit the block pulses `rx_valid` for one cycle with the byte on `rx_data`, and the same byte reads back at address 2.
- R3: The byte last written to address 2 appears on `spi_miso` MSB first. The first bit is present as soon as select goes low, and each later bit follows a falling SCK edge. `spi_miso_oe` is 1 only while the block is an enabled slave with select low.
- R4: Status bit 1 (transfer-end) sets when the 8th bit is captured. A status write with bit 1 = 0 clears it, and so does clearing the enable.
- R5: With control bit 2 (fault-detect) set in slave mode, a select release after at least one captured bit and before the 8th sets status bit 0 (fault). The same event clears control bit 0 and drops `spi_miso_oe`, and the aborted frame produces no `rx_valid`.
- R6: No fault is raised when select is released with no bit captured, or when control bit 2 is 0. In the second case the partial frame is discarded without `rx_valid`, and the enable stays set.
- R7: While the fault flag is set, a control write with bit 0 = 1 leaves the enable at 0. The other control bits are still written.
- R8: The fault flag clears only on a status write with bit 0 = 0 that comes after a status read which saw the flag set, or on reset. Any status write cancels that earlier read, so each clear needs a fresh read.
- R9: `irq_err` is 1 exactly one cycle after the fault flag is set while control bit 3 (error-interrupt enable) is 1. It stays 0 while control bit 3 is 0.
- R10: Clearing the enable aborts the frame, floats MISO and resets the bit counter and shift registers, but keeps the other control bits. A frame clocked after the enable is set again, even within the same select period, is received correctly.
- R11: With control bit 1 (master-select) set, the block neither drives MISO nor receives frames, and it raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered one cycle after `reg_rd` |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output-enable for MISO; 0 means high impedance |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is received |
| irq_err | output | 1 | Error interrupt from the fault flag |

## Verification
Full frames use alternating and asymmetric byte values in both directions, which separates MSB-first from LSB-first order and stuck or shifted bits. Select is released at four points: after the final bit, before any bit, mid-frame with fault detection on, and mid-frame with it off. These separate a real fault from a harmless release and from a silent abort. The clear sequence is tried with no read first, with a read cancelled by a non-clearing write, and with a correct read-then-write, which checks the read latch on its own. A disable while select stays low, followed by a full frame, shows whether the bit counter really restarts.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  localparam int CB_EN   = 0;
  localparam int CB_MSTR = 1;
  localparam int CB_MODF = 2;
  localparam int CB_EIE  = 3;

  localparam int SB_FAULT = 0;
  localparam int SB_TEND  = 1;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= INIT;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spis_shifter.sv
module spis_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              ss_n_s,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              miso_bit,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              frame_done,
  output logic              busy,
  output logic              ss_negate
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q, ss_q;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic              rise, fall;

  assign rise      = sck_s & ~sck_q;
  assign fall      = ~sck_s & sck_q;
  assign ss_negate = ss_n_s & ~ss_q;
  assign busy      = (bitcnt != '0);
  assign miso_bit  = tx_sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q      <= 1'b0;
      ss_q       <= 1'b1;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_byte    <= '0;
      frame_done <= 1'b0;
      miso_oe    <= 1'b0;
    end else begin
      sck_q      <= sck_s;
      ss_q       <= ss_n_s;
      frame_done <= 1'b0;
      miso_oe    <= run & ~ss_n_s;
      if (!run || ss_n_s) begin
        bitcnt <= '0;
        rx_sh  <= '0;
        tx_sh  <= tx_byte;
      end else begin
        if (rise) begin
          rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
          if (bitcnt == LAST) begin
            bitcnt     <= '0;
            rx_byte    <= {rx_sh[DATA_W-2:0], mosi_s};
            frame_done <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        if (fall) begin
          if (bitcnt == '0) tx_sh <= tx_byte;
          else              tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  assert_oe_when_run_R3: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> $past(run));
  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> !busy);
endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              frame_done,
  input  logic              busy,
  input  logic              ss_negate,
  output logic              run,
  output logic [DATA_W-1:0] tx_byte,
  output logic              irq_err
);
  logic ctrl_en, ctrl_mstr, ctrl_modf, ctrl_eie;
  logic fault, tend, seen;
  logic fault_evt, wr_ctrl, wr_stat, wr_data, rd_stat;

  assign run       = ctrl_en & ~ctrl_mstr;
  assign fault_evt = run & ctrl_modf & busy & ss_negate;
  assign wr_ctrl   = reg_wr & (reg_addr == A_CTRL);
  assign wr_stat   = reg_wr & (reg_addr == A_STAT);
  assign wr_data   = reg_wr & (reg_addr == A_DATA);
  assign rd_stat   = reg_rd & (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_mstr <= 1'b0;
      ctrl_modf <= 1'b0;
      ctrl_eie  <= 1'b0;
      fault     <= 1'b0;
      tend      <= 1'b0;
      seen      <= 1'b0;
      tx_byte   <= '0;
      irq_err   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en   <= reg_wdata[CB_EN] & ~fault;
        ctrl_mstr <= reg_wdata[CB_MSTR];
        ctrl_modf <= reg_wdata[CB_MODF];
        ctrl_eie  <= reg_wdata[CB_EIE];
      end
      if (wr_data) tx_byte <= reg_wdata;
      if (rd_stat && fault) seen <= 1'b1;
      if (wr_stat) begin
        seen <= 1'b0;
        if (seen && !reg_wdata[SB_FAULT]) fault <= 1'b0;
        if (!reg_wdata[SB_TEND]) tend <= 1'b0;
      end
      if (frame_done) tend <= 1'b1;
      if (!ctrl_en) tend <= 1'b0;
      if (fault_evt) begin
        fault   <= 1'b1;
        ctrl_en <= 1'b0;
      end
      irq_err <= fault & ctrl_eie;
      if (reg_rd) begin
        reg_rdata <= '0;
        case (reg_addr)
          A_CTRL: begin
            reg_rdata[CB_EN]   <= ctrl_en;
            reg_rdata[CB_MSTR] <= ctrl_mstr;
            reg_rdata[CB_MODF] <= ctrl_modf;
            reg_rdata[CB_EIE]  <= ctrl_eie;
          end
          A_STAT: begin
            reg_rdata[SB_FAULT] <= fault;
            reg_rdata[SB_TEND]  <= tend;
          end
          A_DATA:  reg_rdata <= rx_byte;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_fault_sets_R5: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> (fault && !ctrl_en));
  assert_en_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    fault |-> !ctrl_en);
  assert_clear_by_write_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(fault) |-> $past(wr_stat));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> $past(ctrl_eie));
endmodule

// File: rtl/spi_slave_guard.sv
module spi_slave_guard
  import spis_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              irq_err
);
  logic [2:0]        pins_s;
  logic              run, busy, ss_negate, miso_bit;
  logic [DATA_W-1:0] tx_byte;

  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_ss_n, spi_mosi, spi_sck}),
    .q   (pins_s)
  );

  spis_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .sck_s      (pins_s[0]),
    .mosi_s     (pins_s[1]),
    .ss_n_s     (pins_s[2]),
    .tx_byte    (tx_byte),
    .miso_bit   (miso_bit),
    .miso_oe    (spi_miso_oe),
    .rx_byte    (rx_data),
    .frame_done (rx_valid),
    .busy       (busy),
    .ss_negate  (ss_negate)
  );

  spis_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rx_byte    (rx_data),
    .frame_done (rx_valid),
    .busy       (busy),
    .ss_negate  (ss_negate),
    .run        (run),
    .tx_byte    (tx_byte),
    .irq_err    (irq_err)
  );

  assign spi_miso = miso_bit & spi_miso_oe;

  assert_float_on_fault_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_err && !$past(run)) |-> !spi_miso_oe);
  assert_master_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !run |=> !rx_valid);
endmodule

// File: tb/sim_spi_slave_guard.sv
module sim_spi_slave_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       miso, miso_oe, rx_valid, irq;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_q [$];
  logic oe_seen;

  always #5 clk = ~clk;

  spi_slave_guard u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(sck), .spi_mosi(mosi),
    .spi_ss_n(ss_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .irq_err(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every received byte must match the next expected one
  always @(negedge clk) begin
    if (!rst) begin
      if (miso_oe) oe_seen = 1'b1;
      if (rx_valid) begin
        if (exp_q.size() == 0) chk("R6 unexpected rx_valid", {24'd0, rx_data}, 32'hFFFF_FFFF);
        else chk("R2 received byte", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic sel();
    @(negedge clk); ss_n = 1'b0; wait_clk(8);
  endtask

  task automatic desel();
    @(negedge clk); ss_n = 1'b1; wait_clk(8);
  endtask

  task automatic spi_bit(input logic b, output logic m);
    @(negedge clk); mosi = b; wait_clk(6);
    m = miso; sck = 1'b1; wait_clk(6);
    sck = 1'b0;
  endtask

  // driver: one full frame, expected received byte pushed to the scoreboard
  task automatic frame(input logic [7:0] mo, input bit expect_rx, output logic [7:0] got);
    logic m;
    if (expect_rx) exp_q.push_back(mo);
    sel();
    for (int i = 7; i >= 0; i--) begin
      spi_bit(mo[i], m);
      got[i] = m;
    end
    wait_clk(6);
    desel();
  endtask

  logic [7:0] rd, got;
  logic m;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(4); rst = 1'b0; wait_clk(2);
    // R1 reset state
    reg_read(2'd0, rd); chk("R1 ctrl after reset", rd, 0);
    reg_read(2'd1, rd); chk("R1 status after reset", rd, 0);
    chk("R1 oe/irq/rx_valid after reset", {miso_oe, irq, rx_valid}, 0);

    // R2 R3 basic frame
    reg_write(2'd2, 8'hC6);
    reg_write(2'd0, 8'h01);
    frame(8'hA5, 1, got);
    chk("R3 MISO byte", got, 8'hC6);
    reg_read(2'd2, rd); chk("R2 data read", rd, 8'hA5);
    reg_read(2'd1, rd); chk("R4 tend set", rd[1], 1);
    reg_write(2'd1, 8'h01);
    reg_read(2'd1, rd); chk("R4 tend cleared by write", rd, 0);
    chk("R3 oe low when deselected", miso_oe, 0);

    reg_write(2'd2, 8'h3C);
    frame(8'h1E, 1, got);
    chk("R3 MISO second byte", got, 8'h3C);
    reg_write(2'd0, 8'h00);
    reg_read(2'd1, rd); chk("R4 tend cleared by disable", rd[1], 0);

    // R6 select released before first bit, fault detection on
    reg_write(2'd0, 8'h05);
    sel(); desel();
    reg_read(2'd1, rd); chk("R6 no fault without bits", rd[0], 0);
    // R6 mid-frame release with fault detection off
    reg_write(2'd0, 8'h01);
    sel(); for (int i = 0; i < 3; i++) spi_bit(1'b1, m); desel();
    reg_read(2'd1, rd); chk("R6 no fault when detection off", rd[0], 0);
    reg_read(2'd0, rd); chk("R6 enable kept", rd[0], 1);

    // R5 fault with interrupt enabled
    reg_write(2'd0, 8'h0D);
    sel(); for (int i = 0; i < 3; i++) spi_bit(1'b0, m); desel();
    chk("R5 MISO floated", miso_oe, 0);
    chk("R9 irq raised", irq, 1);
    reg_read(2'd0, rd); chk("R5 enable self-cleared", rd, 8'h0C);
    reg_write(2'd0, 8'h0D);
    reg_read(2'd0, rd); chk("R7 enable write ignored", rd, 8'h0C);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, rd); chk("R8 no clear without read", rd[0], 1);
    reg_write(2'd1, 8'h01);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, rd); chk("R8 read cancelled by write", rd[0], 1);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, rd); chk("R8 cleared after read+write", rd[0], 0);
    wait_clk(2);
    chk("R9 irq dropped", irq, 0);

    // R9 fault with interrupt disabled
    reg_write(2'd0, 8'h05);
    sel(); spi_bit(1'b1, m); desel();
    chk("R9 irq gated off", irq, 0);
    reg_read(2'd1, rd); chk("R9 fault visible by poll", rd[0], 1);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, rd); chk("R8 cleared", rd[0], 0);

    // R10 disable mid-frame, re-enable within same select
    reg_write(2'd2, 8'h81);
    reg_write(2'd0, 8'h01);
    sel(); for (int i = 0; i < 4; i++) spi_bit(1'b1, m);
    reg_write(2'd0, 8'h00);
    wait_clk(4);
    chk("R10 MISO floated on disable", miso_oe, 0);
    reg_write(2'd0, 8'h01);
    wait_clk(6);
    exp_q.push_back(8'h4B);
    for (int i = 7; i >= 0; i--) begin
      spi_bit(((8'h4B >> i) & 8'h01) != 0, m);
      got[i] = m;
    end
    wait_clk(6); desel();
    chk("R10 MISO after restart", got, 8'h81);
    reg_read(2'd2, rd); chk("R10 byte after restart", rd, 8'h4B);

    // R11 master-select set: quiet
    reg_write(2'd0, 8'h07);
    oe_seen = 1'b0;
    frame(8'hFF, 0, got);
    chk("R11 MISO never driven", oe_seen, 0);
    sel(); spi_bit(1'b1, m); desel();
    reg_read(2'd1, rd); chk("R11 no fault", rd[0], 0);
    reg_read(2'd2, rd); chk("R11 no reception", rd, 8'h4B);

    wait_clk(4);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule